// File: doc/BRIEF.md
# Direct-Mapped Secondary Cache Controller

This block steers a direct-mapped secondary cache whose data array is built from ordinary SRAMs and whose tags live in an external tag RAM. When the CPU starts a cycle, the block captures the address, presents the line index to the tag RAM and, one cycle later, compares the returned tag with the upper address bits. The cycle then takes one of four paths. A hit runs the SRAM chip-select, output-enable and write-enable sequence and returns one ready per beat. A clean miss asks memory for a line fill. A miss on a dirty line first asks memory to write the victim line back and then asks for the fill. An access that cannot be cached is handed to memory as a bypass.

A line is 16 bytes, so a burst moves four 32-bit words. Configuration inputs set the cache size, how many tag bits are compared (this sets the cacheable range), the write policy (write-back or write-through), and whether the data array is one bank or two banks interleaved by word. They also select the read burst timing and the write timing. Configuration is held stable while a cycle is in progress. The data path to and from memory is outside this block; memory answers every request with a one-cycle `mem_ack`.

Top module: `l2dm_ctrl`

## Requirements
- R1: In the cycle after `cpu_ads` is sampled, exactly one of `hit` or `miss` is high. `hit` needs all three of: valid bit `tag_q[9]` set, the low `cfg_tw` bits of `tag_q[7:0]` equal to the same bits of the address tag, and the address inside the cacheable range.
- R2: With S = 16 + `cfg_size` (`cfg_size` 0..4 gives 64K..1M), `tag_idx` is address bits [S-1:4] with the upper bits zero, and the address tag is the address shifted right by S.
- R3: An address at or above 2^(S+`cfg_tw`) always misses. It raises `byp_req` until `mem_ack` and never writes the tag RAM.
- R4: Read hit beat timing, counted in clocks from the edge that samples `cpu_ads`, by `cfg_rd_mode`: 0 = 2-1-1-1, 1 = 2-2-2-2, 2 or 3 = 3-2-2-2. When `cfg_ilv`=1, mode 1 runs as 3-2-2-2.
- R5: Write hit timing: with `cfg_wr_slow`=0, single writes complete with 0 wait states (ready 2 clocks after the sampling edge) and bursts run 2-1-1-1. With `cfg_wr_slow`=1, single writes take 1 wait state and bursts run 3-2-2-2.
- R6: Beat k addresses word (addr[3:2]+k) mod 4, and that word appears on `sram_word`. The bank is word bit 0 when `cfg_ilv`=1 and bank 0 otherwise. Reads drive `sram_oe` on that bank only. Writes pulse `sram_we` on that bank only, in the cycle `cpu_rdy` is high.
- R7: A write hit on a clean line in write-back mode (`cfg_wb`=1) pulses `tag_we` in the compare cycle, with `tag_wd` = {1,1,tag}. Write-through never writes the tag on a hit.
- R8: In write-back mode, a miss on a valid dirty line raises `vict_req` first, with `vict_addr` = {stored tag, index, 4'b0}. After `mem_ack` it raises `fill_req`.
- R9: `fill_req` stays high until `mem_ack`. In the acknowledged cycle `tag_we` pulses with `tag_wd` = {valid=1, dirty=(write and write-back), tag}.
- R10: A write miss under write-through does not allocate. It raises `byp_req` and does not write the tag RAM.
- R11: During reset, `cpu_rdy`, `hit`, `miss`, all requests, `tag_we` and all SRAM strobes are low.
- R12: A single access (`cpu_burst`=0) gives one ready. A burst gives four.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_ads | input | 1 | Cycle start, sampled when idle |
| cpu_addr | input | 32 | CPU byte address |
| cpu_wr | input | 1 | 1 = write cycle |
| cpu_burst | input | 1 | 1 = four-beat line burst |
| cfg_size | input | 3 | Cache size code 0..4 (64K..1M) |
| cfg_tw | input | 4 | Compared tag bits 0..8 |
| cfg_wb | input | 1 | 1 = write-back, 0 = write-through |
| cfg_ilv | input | 1 | 1 = two word-interleaved banks |
| cfg_rd_mode | input | 2 | Read burst timing code |
| cfg_wr_slow | input | 1 | Slow write timing |
| tag_q | input | 10 | Tag RAM data {valid, dirty, tag[7:0]} |
| tag_idx | output | 16 | Tag RAM index |
| tag_we | output | 1 | Tag RAM write strobe |
| tag_wd | output | 10 | Tag RAM write data |
| hit | output | 1 | Hit, compare cycle |
| miss | output | 1 | Miss, compare cycle |
| cpu_rdy | output | 1 | Beat ready |
| sram_cs | output | 2 | Data SRAM chip select per bank |
| sram_oe | output | 2 | Data SRAM output enable per bank |
| sram_we | output | 2 | Data SRAM write enable per bank |
| sram_word | output | 2 | Word within the line |
| vict_req | output | 1 | Victim write-back request |
| vict_addr | output | 32 | Victim line address |
| fill_req | output | 1 | Line fill request |
| byp_req | output | 1 | Uncached access request |
| mem_ack | input | 1 | Memory completes current request |

## Verification
`hit`, `miss` and `tag_idx` are due one clock after the edge that samples `cpu_ads`. Beat k of a hit is due at lead-1+k*rest clocks after that edge, so the bench builds a bit mask of ready cycles and compares it with the expected mask for each timing mode. Requests appear from the second clock on. The bench answers each request in the cycle it first sees it, and checks `tag_we` one step after raising `mem_ack` within that same cycle. All sampling is done a moment after the falling edge, counted from the sampling edge.

// File: rtl/l2dm_ctrl.sv
module l2dm_ctrl #(
  parameter int ADDR_W    = 32,
  parameter int TAG_W     = 8,
  parameter int MIN_SET_B = 16,
  parameter int SIZES     = 5,
  localparam int IDX_W    = MIN_SET_B + SIZES - 1 - 4,
  localparam int TW_W     = $clog2(TAG_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_ads,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic              cpu_burst,
  input  logic [2:0]        cfg_size,
  input  logic [TW_W-1:0]   cfg_tw,
  input  logic              cfg_wb,
  input  logic              cfg_ilv,
  input  logic [1:0]        cfg_rd_mode,
  input  logic              cfg_wr_slow,
  input  logic [TAG_W+1:0]  tag_q,
  output logic [IDX_W-1:0]  tag_idx,
  output logic              tag_we,
  output logic [TAG_W+1:0]  tag_wd,
  output logic              hit,
  output logic              miss,
  output logic              cpu_rdy,
  output logic [1:0]        sram_cs,
  output logic [1:0]        sram_oe,
  output logic [1:0]        sram_we,
  output logic [1:0]        sram_word,
  output logic              vict_req,
  output logic [ADDR_W-1:0] vict_addr,
  output logic              fill_req,
  output logic              byp_req,
  input  logic              mem_ack
);

  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_DATA, S_VICT, S_FILL, S_BYP} st_t;

  st_t               st;
  logic [ADDR_W-1:0] a_q;
  logic              wr_q, bst_q;
  logic [1:0]        beat, cnt;
  logic [TAG_W-1:0]  vt_q;

  logic [2:0]        size_c;
  logic [TW_W-1:0]   tw_c;
  logic [5:0]        sb;
  logic [TAG_W-1:0]  tag_of, tmask;
  logic              cacheable, hit_c, adv, done, last, act;
  logic [1:0]        lead, rest, need, word;
  logic              bank;

  assign size_c    = (cfg_size > 3'(SIZES - 1)) ? 3'(SIZES - 1) : cfg_size;
  assign tw_c      = (cfg_tw > TW_W'(TAG_W)) ? TW_W'(TAG_W) : cfg_tw;
  assign sb        = 6'(MIN_SET_B) + 6'(size_c);
  assign tag_of    = TAG_W'(a_q >> sb);
  assign tmask     = ~({TAG_W{1'b1}} << tw_c);
  assign cacheable = (a_q >> ({1'b0, sb} + 7'(tw_c))) == '0;
  assign hit_c     = (st == S_LOOK) && cacheable && tag_q[TAG_W+1]
                     && (((tag_q[TAG_W-1:0] ^ tag_of) & tmask) == '0);

  always_comb begin
    if (wr_q) begin
      lead = cfg_wr_slow ? 2'd3 : 2'd2;
      rest = cfg_wr_slow ? 2'd2 : 2'd1;
    end else begin
      case (cfg_rd_mode)
        2'd0:    begin lead = 2'd2; rest = 2'd1; end
        2'd1:    begin lead = cfg_ilv ? 2'd3 : 2'd2; rest = 2'd2; end
        default: begin lead = 2'd3; rest = 2'd2; end
      endcase
    end
  end

  assign need = (beat == 2'd0) ? lead : rest;
  assign adv  = hit_c || (st == S_DATA);
  assign done = adv && (cnt == need);
  assign last = !bst_q || (beat == 2'd3);
  assign act  = (st == S_LOOK) || (st == S_DATA);
  assign word = a_q[3:2] + beat;
  assign bank = cfg_ilv & word[0];

  assign sram_word = word;
  assign sram_cs   = act ? (bank ? 2'b10 : 2'b01) : 2'b00;
  assign sram_oe   = (act && !wr_q) ? sram_cs : 2'b00;
  assign sram_we   = (done && wr_q) ? sram_cs : 2'b00;
  assign cpu_rdy   = done;
  assign hit       = hit_c;
  assign miss      = (st == S_LOOK) && !hit_c;

  assign tag_idx   = IDX_W'(a_q >> 4) & ~({IDX_W{1'b1}} << (sb - 6'd4));
  assign vict_addr = (ADDR_W'(vt_q) << sb) | (a_q & ~({ADDR_W{1'b1}} << sb) & ~ADDR_W'(15));
  assign vict_req  = (st == S_VICT);
  assign fill_req  = (st == S_FILL);
  assign byp_req   = (st == S_BYP);

  assign tag_we = (hit_c && wr_q && cfg_wb && !tag_q[TAG_W]) || ((st == S_FILL) && mem_ack);
  assign tag_wd = (st == S_FILL) ? {1'b1, wr_q & cfg_wb, tag_of} : {1'b1, 1'b1, tag_of};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      a_q   <= '0;
      wr_q  <= 1'b0;
      bst_q <= 1'b0;
      beat  <= 2'd0;
      cnt   <= 2'd0;
      vt_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (cpu_ads) begin
          a_q   <= cpu_addr;
          wr_q  <= cpu_wr;
          bst_q <= cpu_burst;
          beat  <= 2'd0;
          cnt   <= 2'd2;
          st    <= S_LOOK;
        end
        S_LOOK, S_DATA: begin
          if (adv) begin
            if (done) begin
              if (last) st <= S_IDLE;
              else begin
                st   <= S_DATA;
                beat <= beat + 2'd1;
                cnt  <= 2'd1;
              end
            end else begin
              st  <= S_DATA;
              cnt <= cnt + 2'd1;
            end
          end else if (!cacheable || (wr_q && !cfg_wb)) begin
            st <= S_BYP;
          end else if (cfg_wb && tag_q[TAG_W+1] && tag_q[TAG_W]) begin
            st   <= S_VICT;
            vt_q <= tag_q[TAG_W-1:0];
          end else begin
            st <= S_FILL;
          end
        end
        S_VICT: if (mem_ack) st <= S_FILL;
        S_FILL, S_BYP: if (mem_ack) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module l2dm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_ilv,
  input logic       hit,
  input logic       miss,
  input logic       cpu_rdy,
  input logic [1:0] sram_cs,
  input logic [1:0] sram_oe,
  input logic [1:0] sram_we,
  input logic       vict_req,
  input logic       fill_req,
  input logic       byp_req,
  input logic       mem_ack
);
  // R1
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(hit && miss));
  // R6
  we_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(sram_we));
  // R6
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !((|sram_oe) && (|sram_we)));
  // R6
  bank1_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ilv |-> (sram_cs[1] == 1'b0 && sram_oe[1] == 1'b0 && sram_we[1] == 1'b0));
  // R8
  vict_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n) vict_req && mem_ack |=> fill_req);
  // R9
  fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) fill_req && !mem_ack |=> fill_req);
  // R3
  byp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) byp_req && !mem_ack |=> byp_req);
  // R12
  rdy_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdy |-> !(vict_req || fill_req || byp_req));
endmodule

bind l2dm_ctrl l2dm_chk u_l2dm_chk (
  .clk(clk), .rst_n(rst_n), .cfg_ilv(cfg_ilv), .hit(hit), .miss(miss),
  .cpu_rdy(cpu_rdy), .sram_cs(sram_cs), .sram_oe(sram_oe), .sram_we(sram_we),
  .vict_req(vict_req), .fill_req(fill_req), .byp_req(byp_req), .mem_ack(mem_ack)
);

// File: tb/test_l2dm_ctrl.sv
module test_l2dm_ctrl;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cpu_ads = 0, cpu_wr = 0, cpu_burst = 0;
  logic [31:0] cpu_addr = '0;
  logic [2:0]  cfg_size = 0;
  logic [3:0]  cfg_tw = 4'd8;
  logic        cfg_wb = 1, cfg_ilv = 0, cfg_wr_slow = 0;
  logic [1:0]  cfg_rd_mode = 0;
  logic [9:0]  tag_q = '0;
  logic [15:0] tag_idx;
  logic        tag_we, hit, miss, cpu_rdy, vict_req, fill_req, byp_req;
  logic        mem_ack = 0;
  logic [9:0]  tag_wd;
  logic [1:0]  sram_cs, sram_oe, sram_we, sram_word;
  logic [31:0] vict_addr;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  l2dm_ctrl i_l2dm_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_ads(cpu_ads), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cpu_burst(cpu_burst), .cfg_size(cfg_size), .cfg_tw(cfg_tw), .cfg_wb(cfg_wb),
    .cfg_ilv(cfg_ilv), .cfg_rd_mode(cfg_rd_mode), .cfg_wr_slow(cfg_wr_slow),
    .tag_q(tag_q), .tag_idx(tag_idx), .tag_we(tag_we), .tag_wd(tag_wd), .hit(hit),
    .miss(miss), .cpu_rdy(cpu_rdy), .sram_cs(sram_cs), .sram_oe(sram_oe),
    .sram_we(sram_we), .sram_word(sram_word), .vict_req(vict_req),
    .vict_addr(vict_addr), .fill_req(fill_req), .byp_req(byp_req), .mem_ack(mem_ack));

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic start(input logic [31:0] a, input logic w, input logic b, input logic [9:0] tq);
    @(negedge clk);
    mem_ack = 0; cpu_ads = 1; cpu_addr = a; cpu_wr = w; cpu_burst = b; tag_q = tq;
    @(negedge clk);
    cpu_ads = 0;
    #1;
  endtask

  typedef struct packed {
    logic [31:0] addr; logic wr; logic bst; logic [1:0] rm; logic ws; logic ilv;
    logic wb; logic [3:0] tw; logic [9:0] tq; logic [15:0] mask; logic [1:0] kind;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VT [NV] = '{
    '{32'h00123450, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 4'd8, 10'h212, 16'h001E, 2'd0},
    '{32'h00123450, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 4'd8, 10'h212, 16'h00AA, 2'd0},
    '{32'h00123450, 1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 1'b1, 4'd8, 10'h212, 16'h0154, 2'd0},
    '{32'h00123450, 1'b0, 1'b1, 2'd1, 1'b0, 1'b1, 1'b1, 4'd8, 10'h212, 16'h0154, 2'd0},
    '{32'h0012345C, 1'b0, 1'b1, 2'd0, 1'b0, 1'b1, 1'b1, 4'd8, 10'h212, 16'h001E, 2'd0},
    '{32'h00123458, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 1'b1, 4'd8, 10'h212, 16'h0004, 2'd0},
    '{32'h00123454, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 4'd8, 10'h212, 16'h0002, 2'd0},
    '{32'h00123450, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 4'd8, 10'h212, 16'h0002, 2'd0},
    '{32'h00123454, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 4'd8, 10'h212, 16'h0004, 2'd0},
    '{32'h00123458, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1, 1'b1, 4'd8, 10'h212, 16'h001E, 2'd0},
    '{32'h00123450, 1'b1, 1'b1, 2'd0, 1'b1, 1'b0, 1'b1, 4'd8, 10'h212, 16'h0154, 2'd0},
    '{32'h00123450, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 4'd8, 10'h213, 16'h0000, 2'd1},
    '{32'h00123450, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 4'd8, 10'h334, 16'h0000, 2'd2},
    '{32'h00123450, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 4'd8, 10'h334, 16'h0000, 2'd1},
    '{32'h01000010, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 4'd8, 10'h200, 16'h0000, 2'd3},
    '{32'h00123450, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 4'd4, 10'h212, 16'h0000, 2'd3},
    '{32'h00123450, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 4'd8, 10'h213, 16'h0000, 2'd3},
    '{32'h00123450, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 4'd8, 10'h012, 16'h0000, 2'd1}
  };

  task automatic drain(input int n);
    for (int s = 0; s < n; s++) begin
      @(negedge clk);
      mem_ack = 0;
      #1;
      if (vict_req || fill_req || byp_req) mem_ack = 1;
    end
    @(negedge clk);
    mem_ack = 0;
  endtask

  bit finished = 0;

  initial begin
    #(20 * 200000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] mask;
    logic [1:0]  kind, wexp;
    logic        bexp;
    logic [1:0]  sel;
    bit vs, fs, bs;
    int nb;

    repeat (3) @(negedge clk);
    #1;
    // R11 reset state
    chk({cpu_rdy, hit, miss, vict_req, fill_req, byp_req, tag_we} == 7'b0, "R11 reset flags",
        {cpu_rdy, hit, miss, vict_req, fill_req, byp_req, tag_we}, 0);
    chk({sram_cs, sram_oe, sram_we} == 6'b0, "R11 reset strobes", {sram_cs, sram_oe, sram_we}, 0);
    @(negedge clk);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      cfg_size = 0; cfg_tw = VT[i].tw; cfg_wb = VT[i].wb; cfg_ilv = VT[i].ilv;
      cfg_rd_mode = VT[i].rm; cfg_wr_slow = VT[i].ws;
      start(VT[i].addr, VT[i].wr, VT[i].bst, VT[i].tq);
      mask = '0; nb = 0; vs = 0; fs = 0; bs = 0;
      for (int s = 1; s <= 13; s++) begin
        if (s > 1) begin
          @(negedge clk);
          mem_ack = 0;
          #1;
        end
        if (s == 1) chk(hit == (VT[i].kind == 2'd0) && miss == (VT[i].kind != 2'd0),
                        $sformatf("R1 vec%0d hit/miss", i), {hit, miss}, {VT[i].kind == 0, VT[i].kind != 0});
        if (cpu_rdy) begin
          mask[s] = 1'b1;
          wexp = VT[i].addr[3:2] + 2'(nb);
          bexp = VT[i].ilv & wexp[0];
          sel  = bexp ? 2'b10 : 2'b01;
          chk(sram_word == wexp, $sformatf("R6 vec%0d beat%0d word", i, nb), sram_word, wexp);
          if (VT[i].wr)
            chk(sram_we == sel && sram_oe == 2'b00, $sformatf("R6 vec%0d beat%0d we", i, nb), {sram_oe, sram_we}, sel);
          else
            chk(sram_oe == sel && sram_we == 2'b00, $sformatf("R6 vec%0d beat%0d oe", i, nb), {sram_oe, sram_we}, {sel, 2'b00});
          nb++;
        end
        if (vict_req) vs = 1;
        if (fill_req) fs = 1;
        if (byp_req) bs = 1;
        if (vict_req || fill_req || byp_req) mem_ack = 1;
      end
      @(negedge clk);
      mem_ack = 0;
      chk(mask == VT[i].mask, $sformatf("R4/R5/R12 vec%0d ready cycles", i), mask, VT[i].mask);
      kind = vs ? 2'd2 : fs ? 2'd1 : bs ? 2'd3 : 2'd0;
      if (vs) chk(fs, $sformatf("R8 vec%0d fill after victim", i), fs, 1);
      chk(kind == VT[i].kind, $sformatf("R1/R3/R8/R10 vec%0d outcome", i), kind, VT[i].kind);
    end

    // R2 index split at 1M and 64K
    cfg_tw = 4'd8; cfg_wb = 1; cfg_ilv = 0; cfg_rd_mode = 0; cfg_wr_slow = 0;
    cfg_size = 3'd4;
    start(32'h000ABCD0, 1'b0, 1'b0, 10'h200);
    chk(tag_idx == 16'hABCD, "R2 index 1M", tag_idx, 16'hABCD);
    chk(hit == 1'b1, "R2 tag 1M hit", hit, 1);
    drain(6);
    cfg_size = 3'd0;
    start(32'h000ABCD0, 1'b0, 1'b0, 10'h200);
    chk(tag_idx == 16'h0BCD, "R2 index 64K", tag_idx, 16'h0BCD);
    chk(miss == 1'b1, "R2 tag 64K miss", miss, 1);
    drain(6);

    // R7 write-back write hit on clean line
    start(32'h00123450, 1'b1, 1'b0, 10'h212);
    chk(tag_we == 1'b1 && tag_wd == 10'h312, "R7 dirty set", {tag_we, tag_wd}, {1'b1, 10'h312});
    drain(4);
    cfg_wb = 0;
    start(32'h00123450, 1'b1, 1'b0, 10'h212);
    chk(tag_we == 1'b0, "R7 write-through no tag write", tag_we, 0);
    drain(4);
    cfg_wb = 1;

    // R8 victim address, then R9 fill tag write
    start(32'h00123450, 1'b0, 1'b1, 10'h334);
    @(negedge clk); #1;
    chk(vict_req && !fill_req, "R8 victim first", {vict_req, fill_req}, 2'b10);
    chk(vict_addr == 32'h00343450, "R8 victim address", vict_addr, 32'h00343450);
    mem_ack = 1;
    @(negedge clk); mem_ack = 0; #1;
    chk(fill_req == 1'b1, "R8 fill after victim", fill_req, 1);
    mem_ack = 1; #1;
    chk(tag_we && tag_wd == 10'h212, "R9 read fill tag", {tag_we, tag_wd}, {1'b1, 10'h212});
    @(negedge clk); mem_ack = 0;

    // R9 fill held without ack, write-allocate marks dirty
    start(32'h00123450, 1'b1, 1'b0, 10'h213);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk(fill_req && !tag_we, "R9 fill held", {fill_req, tag_we}, 2'b10);
    end
    mem_ack = 1; #1;
    chk(tag_we && tag_wd == 10'h312, "R9 write fill tag", {tag_we, tag_wd}, {1'b1, 10'h312});
    @(negedge clk); mem_ack = 0; #1;
    chk(!fill_req, "R9 fill released", fill_req, 0);

    // R3 uncached access never writes tag
    start(32'h01000010, 1'b1, 1'b0, 10'h200);
    @(negedge clk); #1;
    mem_ack = 1; #1;
    chk(byp_req && !tag_we, "R3 bypass no tag write", {byp_req, tag_we}, 2'b10);
    @(negedge clk); mem_ack = 0;
    // R10 write-through write miss does not fill
    cfg_wb = 0;
    start(32'h00123450, 1'b1, 1'b1, 10'h213);
    @(negedge clk); #1;
    chk(byp_req && !fill_req, "R10 no allocate", {byp_req, fill_req}, 2'b10);
    drain(3);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule